// File: doc/BRIEF.md
# Flash-to-RAM Burst Copier

This block lets a processor move a block of data from a slow serial flash or texture memory into its own 32-bit working RAM without running a copy loop. Software sets the copy up through a single memory-mapped register, using three writes whose top two data bits say what each write means. It sets the length first, then the destination word address in RAM, and finally the 24-bit source address in flash. That last write also launches the transfer.

Once a transfer starts, the block asks the flash engine for a byte stream that begins at the source address. It gathers the bytes four at a time into little-endian words and writes each completed word into RAM at consecutive word addresses. For the whole burst the block owns the RAM write port and raises a stall to the processor, because the RAM can be written on any cycle and the processor cannot fetch instructions. When the programmed number of words has been written, the port goes back to the processor. A registered busy flag combines flash-engine activity with burst activity, so software can poll it from its status register.

Top module: `flash_burst_copier`

## Requirements
- R1: A configuration write with data bit 31 = 1 loads the transfer length in words from data bits 23:2 (length in bytes divided by four). Bit 30 is ignored in this case, so no transfer starts.
- R2: A configuration write with bits 31:30 = 00 loads the RAM destination word address from data bits 23:2. Bits 1:0 are dropped.
- R3: A configuration write with bits 31:30 = 01 and a non-zero length takes the source address from bits 23:0. On the next cycle, `flash_start` is high for exactly one cycle and `flash_addr` holds that address.
- R4: That source write raises `cpu_stall` on the next cycle. If the programmed length is zero, no burst starts: there is no stall and no `flash_start`.
- R5: Bytes pack little-endian, so the first byte of each group of four goes to bits 7:0 and the fourth goes to bits 31:24. Cycles with `flash_byte_valid` low leave the packing position unchanged.
- R6: Each completed word appears on the RAM port the cycle after its fourth byte is accepted. The first word goes to the destination address, and each later word goes to the next word address. The destination register keeps advancing across bursts.
- R7: `cpu_stall` falls in the same cycle as the last word's write. Bytes that arrive after the end of the burst cause no RAM write.
- R8: While stalled, the processor's RAM requests are not forwarded to the RAM, so the RAM is written only by the copier. When idle, a processor request appears on the RAM port one cycle later.
- R9: Configuration writes made while a burst runs are ignored.
- R10: `status_busy` is high one cycle after `flash_busy` or the burst activity is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the copier's mapped register |
| cfg_wdata | input | 32 | Tagged configuration data |
| cpu_ram_we | input | 1 | Processor RAM write request |
| cpu_ram_addr | input | 22 | Processor RAM word address |
| cpu_ram_wdata | input | 32 | Processor RAM write data |
| flash_busy | input | 1 | Flash engine activity flag |
| flash_byte_valid | input | 1 | A stream byte is present this cycle |
| flash_byte | input | 8 | Stream byte |
| flash_start | output | 1 | One-cycle pulse that starts a flash read |
| flash_addr | output | 24 | Flash source byte address |
| cpu_stall | output | 1 | Processor hold during a burst |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 22 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| status_busy | output | 1 | Busy flag for the status register |

## Verification
A corrupted packing position shows up on the RAM port at the next word boundary: the write comes too early, too late, or with bytes in the wrong lanes. A wrong remaining count or destination shows within one burst, as a stall that ends at the wrong word or a write to an address that is not the expected one. A broken configuration gate shows only on the next burst, so the bench runs a second burst that reuses the destination left over from the first. Forwarding errors show one cycle after a processor request, both inside and outside a burst.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int LANES   = WORD_W / BYTE_W;
  localparam int CUR_W   = LANES + 1;
  localparam int FIELD_W = 22;
  localparam int SRC_W   = 24;

  typedef enum logic [1:0] {
    CFG_DEST    = 2'b00,
    CFG_SRC     = 2'b01,
    CFG_LEN     = 2'b10,
    CFG_LEN_ALT = 2'b11
  } cfg_kind_e;
endpackage

// File: rtl/fbc_ctrl.sv
module fbc_ctrl
  import fbc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [WORD_W-1:0]  cfg_wdata,
  input  logic               word_done,
  output logic               active,
  output logic               fl_start,
  output logic [SRC_W-1:0]   fl_addr,
  output logic [FIELD_W-1:0] dest
);
  logic [FIELD_W-1:0] len_q;
  logic [FIELD_W-1:0] rem_q;
  logic [FIELD_W-1:0] field;
  cfg_kind_e          kind;
  logic               unused_cfg;

  assign field      = cfg_wdata[FIELD_W+1:2];
  assign kind       = cfg_kind_e'(cfg_wdata[WORD_W-1:WORD_W-2]);
  assign unused_cfg = ^{cfg_wdata[WORD_W-3:SRC_W], cfg_wdata[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= '0;
      rem_q    <= '0;
      dest     <= '0;
      fl_addr  <= '0;
      active   <= 1'b0;
      fl_start <= 1'b0;
    end else begin
      fl_start <= 1'b0;
      if (cfg_we && !active) begin
        case (kind)
          CFG_LEN, CFG_LEN_ALT: len_q <= field;
          CFG_DEST:             dest  <= field;
          default: begin
            fl_addr <= cfg_wdata[SRC_W-1:0];
            if (len_q != '0) begin
              active   <= 1'b1;
              fl_start <= 1'b1;
              rem_q    <= len_q;
            end
          end
        endcase
      end
      if (word_done) begin
        dest  <= dest + 1'b1;
        rem_q <= rem_q - 1'b1;
        if (rem_q == FIELD_W'(1)) active <= 1'b0;
      end
    end
  end

  AST_DEST_STEP: assert property (@(posedge clk) disable iff (rst)
    word_done |=> dest == $past(dest) + 1'b1); // R6
  AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
    (word_done && rem_q == FIELD_W'(1)) |=> !active); // R7
  AST_REM_LIVE: assert property (@(posedge clk) disable iff (rst)
    active |-> rem_q != '0); // R7
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    fl_start |-> !$past(active)); // R9
  AST_START_ONCE: assert property (@(posedge clk) disable iff (rst)
    fl_start |=> !fl_start); // R3
endmodule

// File: rtl/fbc_packer.sv
module fbc_packer
  import fbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  localparam logic [CUR_W-1:0] CUR_IDLE = CUR_W'(1) << LANES;

  logic [CUR_W-1:0]         cursor;
  logic [CUR_W-1:0]         nxt;
  logic [WORD_W-BYTE_W-1:0] lanes;
  logic                     take;

  assign take      = active && byte_valid;
  assign nxt       = cursor[LANES] ? CUR_W'(1) : (cursor << 1);
  assign word_done = take && nxt[LANES-1];
  assign word      = {byte_in, lanes};

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cursor <= CUR_IDLE;
    end else if (take) begin
      cursor <= nxt[LANES-1] ? CUR_IDLE : nxt;
    end
  end

  for (genvar k = 0; k < LANES - 1; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lanes[k*BYTE_W +: BYTE_W] <= '0;
      else if (take && nxt[k]) lanes[k*BYTE_W +: BYTE_W] <= byte_in;
    end
  end

  AST_CURSOR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(cursor) == 1); // R5
  AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !byte_valid) |=> $stable(cursor) || !active); // R5
endmodule

// File: rtl/fbc_ram_port.sv
module fbc_ram_port
  import fbc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  input  logic               word_done,
  input  logic [FIELD_W-1:0] dest,
  input  logic [WORD_W-1:0]  word,
  input  logic               cpu_we,
  input  logic [FIELD_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  output logic               ram_we,
  output logic [FIELD_W-1:0] ram_addr,
  output logic [WORD_W-1:0]  ram_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else if (word_done) begin
      ram_we    <= 1'b1;
      ram_addr  <= dest;
      ram_wdata <= word;
    end else if (!stall) begin
      ram_we    <= cpu_we;
      ram_addr  <= cpu_addr;
      ram_wdata <= cpu_wdata;
    end else begin
      ram_we    <= 1'b0;
    end
  end

  AST_NO_CPU_WRITE_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    ($past(stall) && ram_we) |-> $past(word_done)); // R8
endmodule

// File: rtl/flash_burst_copier.sv
module flash_burst_copier
  import fbc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [WORD_W-1:0]  cfg_wdata,
  input  logic               cpu_ram_we,
  input  logic [FIELD_W-1:0] cpu_ram_addr,
  input  logic [WORD_W-1:0]  cpu_ram_wdata,
  input  logic               flash_busy,
  input  logic               flash_byte_valid,
  input  logic [BYTE_W-1:0]  flash_byte,
  output logic               flash_start,
  output logic [SRC_W-1:0]   flash_addr,
  output logic               cpu_stall,
  output logic               ram_we,
  output logic [FIELD_W-1:0] ram_addr,
  output logic [WORD_W-1:0]  ram_wdata,
  output logic               status_busy
);
  logic               active;
  logic               word_done;
  logic [WORD_W-1:0]  word;
  logic [FIELD_W-1:0] dest;

  fbc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .word_done(word_done), .active(active), .fl_start(flash_start),
    .fl_addr(flash_addr), .dest(dest)
  );

  fbc_packer u_pack (
    .clk(clk), .rst(rst), .active(active), .byte_valid(flash_byte_valid),
    .byte_in(flash_byte), .word_done(word_done), .word(word)
  );

  fbc_ram_port u_port (
    .clk(clk), .rst(rst), .stall(active), .word_done(word_done),
    .dest(dest), .word(word), .cpu_we(cpu_ram_we), .cpu_addr(cpu_ram_addr),
    .cpu_wdata(cpu_ram_wdata), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata)
  );

  assign cpu_stall = active;

  always_ff @(posedge clk) begin
    if (rst) status_busy <= 1'b0;
    else     status_busy <= flash_busy | active;
  end

  AST_STALL_WITH_START: assert property (@(posedge clk) disable iff (rst)
    flash_start |-> cpu_stall); // R4
endmodule

// File: tb/flash_burst_copier_bench.sv
module flash_burst_copier_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cpu_ram_we = 1'b0;
  logic [21:0] cpu_ram_addr = '0;
  logic [31:0] cpu_ram_wdata = '0;
  logic        flash_busy = 1'b0;
  logic        flash_byte_valid = 1'b0;
  logic [7:0]  flash_byte = '0;
  logic        flash_start;
  logic [23:0] flash_addr;
  logic        cpu_stall;
  logic        ram_we;
  logic [21:0] ram_addr;
  logic [31:0] ram_wdata;
  logic        status_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_burst_copier u_flash_burst_copier (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cpu_ram_we(cpu_ram_we), .cpu_ram_addr(cpu_ram_addr),
    .cpu_ram_wdata(cpu_ram_wdata), .flash_busy(flash_busy),
    .flash_byte_valid(flash_byte_valid), .flash_byte(flash_byte),
    .flash_start(flash_start), .flash_addr(flash_addr), .cpu_stall(cpu_stall),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .status_busy(status_busy)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic push_byte(logic [7:0] b);
    flash_byte_valid = 1'b1; flash_byte = b;
    @(negedge clk);
    flash_byte_valid = 1'b0; flash_byte = '0;
  endtask

  task automatic expect_word(string req, logic [21:0] a, logic [31:0] d);
    check({req, " we"}, 32'(ram_we), 32'd1);
    check({req, " addr"}, 32'(ram_addr), 32'(a));
    check({req, " data"}, ram_wdata, d);
  endtask

  task automatic t_reset();
    check("R4 reset stall", 32'(cpu_stall), 32'd0);
    check("R8 reset ram_we", 32'(ram_we), 32'd0);
    check("R3 reset start", 32'(flash_start), 32'd0);
    check("R10 reset busy", 32'(status_busy), 32'd0);
  endtask

  task automatic t_idle_forward();
    cpu_ram_we = 1'b1; cpu_ram_addr = 22'h00_0ABC; cpu_ram_wdata = 32'h1234_5678;
    @(negedge clk);
    cpu_ram_we = 1'b0;
    expect_word("R8 idle forward", 22'h00_0ABC, 32'h1234_5678);
    @(negedge clk);
    check("R8 idle release", 32'(ram_we), 32'd0);
  endtask

  task automatic t_first_burst();
    cfg_write(32'h8000_0008);
    cfg_write(32'h0000_0103);
    cfg_write(32'h4012_3456);
    check("R3 start pulse", 32'(flash_start), 32'd1);
    check("R3 source addr", 32'(flash_addr), 32'h0012_3456);
    check("R4 stall up", 32'(cpu_stall), 32'd1);
    @(negedge clk);
    check("R3 start once", 32'(flash_start), 32'd0);
    check("R10 busy follows burst", 32'(status_busy), 32'd1);
    cpu_ram_we = 1'b1; cpu_ram_addr = 22'h00_0155; cpu_ram_wdata = 32'hDEAD_BEEF;
    push_byte(8'h11);
    check("R8 cpu blocked", 32'(ram_we), 32'd0);
    push_byte(8'h22);
    @(negedge clk);
    check("R5 gap no write", 32'(ram_we), 32'd0);
    push_byte(8'h33);
    push_byte(8'h44);
    expect_word("R2 R5 first word", 22'h00_0040, 32'h4433_2211);
    check("R7 stall mid", 32'(cpu_stall), 32'd1);
    cfg_write(32'h0000_0040);
    check("R8 no write after word", 32'(ram_we), 32'd0);
    push_byte(8'h55);
    push_byte(8'h66);
    push_byte(8'h77);
    push_byte(8'h88);
    expect_word("R6 second word", 22'h00_0041, 32'h8877_6655);
    check("R7 stall falls", 32'(cpu_stall), 32'd0);
    @(negedge clk);
    cpu_ram_we = 1'b0;
    expect_word("R8 resume forward", 22'h00_0155, 32'hDEAD_BEEF);
  endtask

  task automatic t_second_burst();
    cfg_write(32'h8000_0004);
    cfg_write(32'h4000_0100);
    check("R3 second addr", 32'(flash_addr), 32'h0000_0100);
    push_byte(8'hA1);
    push_byte(8'hB2);
    push_byte(8'hC3);
    push_byte(8'hD4);
    expect_word("R9 R6 dest kept", 22'h00_0042, 32'hD4C3_B2A1);
    check("R7 end single", 32'(cpu_stall), 32'd0);
    push_byte(8'hEE);
    check("R7 extra byte ignored", 32'(ram_we), 32'd0);
    check("R7 no restart", 32'(cpu_stall), 32'd0);
  endtask

  task automatic t_zero_len();
    cfg_write(32'h8000_0000);
    cfg_write(32'h4000_0200);
    check("R4 zero len no stall", 32'(cpu_stall), 32'd0);
    check("R4 zero len no start", 32'(flash_start), 32'd0);
  endtask

  task automatic t_both_bits();
    cfg_write(32'hC000_0004);
    check("R1 both bits no start", 32'(flash_start), 32'd0);
    check("R1 both bits no stall", 32'(cpu_stall), 32'd0);
    cfg_write(32'h4000_0000);
    check("R1 length loaded", 32'(cpu_stall), 32'd1);
    push_byte(8'h01);
    push_byte(8'h02);
    push_byte(8'h03);
    push_byte(8'h04);
    expect_word("R1 one word", 22'h00_0043, 32'h0403_0201);
    check("R1 stall done", 32'(cpu_stall), 32'd0);
  endtask

  task automatic t_flash_busy();
    @(negedge clk);
    check("R10 idle low", 32'(status_busy), 32'd0);
    flash_busy = 1'b1;
    @(negedge clk);
    check("R10 flash busy", 32'(status_busy), 32'd1);
    flash_busy = 1'b0;
    @(negedge clk);
    check("R10 clears", 32'(status_busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_forward();
    t_first_burst();
    t_second_burst();
    t_zero_len();
    t_both_bits();
    t_flash_busy();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule